// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one 32-bit timer channel that counts down from a programmed start value. A free-running reference tick enters the channel and is divided by a programmable 8-bit prescaler. The divided strobe decrements the current count while the channel is enabled. When the count reaches zero, the channel drives a single-clock terminal pulse. That pulse is meant for a shared interrupt-status register that lives outside the block.

Software sees three registers: a control word, an initial-count register and a read-only current count. The channel runs once and stops (one-shot), or reloads and keeps running (periodic). It can be paused and resumed without losing its count. A counter-reset command reloads the count from the initial-count register. The control word is filtered on every write so that reserved and hardware-owned bits cannot be changed by software.

Top module: `tmr_channel`

## Requirements
- R1: After synchronous reset, `ctl_q` reads 0x00000005 and `init_q`, `count_q` and `expire_o` read 0.
- R2: On a control write, bits 24:8 and the active flag (bit 25) are discarded. They read back as 0, while the other written bits (enable 30, interrupt enable 29, periodic 27, prescale 7:0) read back as written.
- R3: A write to the initial-count register sets `init_q` and loads the same value into `count_q` in that same clock edge.
- R4: In one-shot mode (bit 27 = 0), starting from count N > 0, the count reaches 0 on the Nth decrement strobe. On that edge enable (bit 30) and active (bit 25) both clear and counting stops.
- R5: Each zero event drives `expire_o` high for one clock, registered on the same edge as the zero detection and reload.
- R6: In periodic mode (bit 27 = 1), a zero event reloads `count_q` from `init_q` and leaves enable set, so the next period starts at once.
- R7: Writing enable = 0 freezes `count_q` and clears active. Writing enable = 1 again sets active and resumes from the frozen value, not from `init_q`.
- R8: A control write with counter reset (bit 26) reloads `count_q` from `init_q`, and bit 26 always reads 0. If the same write also sets enable, the enable bit is dropped, so the channel ends up stopped.
- R9: A control write that changes the prescale field leaves `count_q` unchanged. Later decrements occur every (new field + 1) reference ticks.
- R10: Decrements happen only on cycles where `tick_i` is high, one every (prescale + 1) ticks while enabled. The count never goes below 0.
- R11: A clock edge on which either register is written performs no decrement and no zero event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference tick strobe |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| init_we | input | 1 | Initial-count write strobe |
| init_wdata | input | 32 | Initial-count write data |
| ctl_q | output | 32 | Control word readback |
| init_q | output | 32 | Initial-count readback |
| count_q | output | 32 | Current count (read-only) |
| expire_o | output | 1 | One-clock terminal pulse on reaching zero |

## Verification
The assertions check these properties on every cycle:
- the counter-reset bit and the reserved field always read 0 (R8, R2);
- active always matches enable;
- a stopped channel with no load holds its count (R7);
- a plain decrement lowers the count by exactly one (R10);
- a one-shot zero event clears enable on the next edge (R4).

Some behaviours depend on sequences of writes and cannot be seen from a single cycle, so only the directed scenarios show them:
- the exact expiry cycle for a given prescale;
- resuming from a frozen count;
- the prescaler rate changing while the count is kept;
- periodic reload timing;
- a write edge swallowing a decrement.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W     = 32;
  localparam int EN_BIT    = 30;
  localparam int IE_BIT    = 29;
  localparam int PER_BIT   = 27;
  localparam int CRST_BIT  = 26;
  localparam int ACT_BIT   = 25;
  localparam int PSC_LSB   = 0;
  localparam int PSC_W     = 8;
  localparam logic [CTL_W-1:0] RSVD_MASK = 32'h01FF_FF00;
  localparam logic [CTL_W-1:0] CTL_RST   = 32'h0000_0005;
endpackage

// File: rtl/tmr_ctl_filter.sv
module tmr_ctl_filter
  import tmr_pkg::*;
(
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] word_o,
  output logic             crst_o,
  output logic             en_o
);
  logic [CTL_W-1:0] masked;

  always_comb begin
    masked = wdata_i & ~RSVD_MASK;
    masked[ACT_BIT] = 1'b0;
    crst_o = masked[CRST_BIT];
    // counter reset wins over enable in the same write
    if (masked[CRST_BIT]) masked[EN_BIT] = 1'b0;
    masked[CRST_BIT] = 1'b0;
    en_o   = masked[EN_BIT];
    word_o = masked;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             strobe_o
);
  logic [DIV_W-1:0] pcnt;
  logic             wrap;

  assign wrap     = (pcnt >= div_i);
  assign strobe_o = run_i & tick_i & wrap & ~restart_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pcnt <= '0;
    end else if (run_i && tick_i) begin
      pcnt <= wrap ? '0 : pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             strobe_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;

  assign step   = run_i & strobe_i & ~hold_i;
  assign zero_o = step & (count_o <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o  <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= zero_o;
      if (load_i) begin
        count_o <= load_val_i;
      end else if (zero_o) begin
        count_o <= periodic_i ? reload_val_i : '0;
      end else if (step) begin
        count_o <= count_o - ONE;
      end
    end
  end

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> (count_o == $past(count_o)));  // R7

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (step && !load_i && count_o > ONE) |=> (count_o == $past(count_o) - ONE));  // R10
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             init_we,
  input  logic [CNT_W-1:0] init_wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CNT_W-1:0] init_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_o
);
  logic [CTL_W-1:0] wr_word;
  logic             wr_crst;
  logic             wr_en;
  logic             act_next;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             restart;
  logic             psc_change;
  logic             en_rise;
  logic             strobe;
  logic             zero_evt;

  tmr_ctl_filter u_filter (
    .wdata_i (ctl_wdata),
    .word_o  (wr_word),
    .crst_o  (wr_crst),
    .en_o    (wr_en)
  );

  assign act_next   = (wr_en != ctl_q[EN_BIT]) ? wr_en : ctl_q[ACT_BIT];
  assign load       = init_we | (ctl_we & wr_crst);
  assign load_val   = init_we ? init_wdata : init_q;
  assign psc_change = ctl_we &
                      (wr_word[PSC_LSB +: PSC_W] != ctl_q[PSC_LSB +: PSC_W]);
  assign en_rise    = ctl_we & wr_en & ~ctl_q[EN_BIT];
  assign restart    = load | psc_change | en_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RST;
    end else if (ctl_we) begin
      ctl_q          <= wr_word;
      ctl_q[ACT_BIT] <= act_next;
    end else if (zero_evt && !ctl_q[PER_BIT]) begin
      ctl_q[EN_BIT]  <= 1'b0;
      ctl_q[ACT_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
    end else if (init_we) begin
      init_q <= init_wdata;
    end
  end

  tmr_prescaler #(.DIV_W(PSC_W)) u_psc (
    .clk       (clk),
    .rst       (rst),
    .run_i     (ctl_q[EN_BIT]),
    .tick_i    (tick_i),
    .restart_i (restart),
    .div_i     (ctl_q[PSC_LSB +: PSC_W]),
    .strobe_o  (strobe)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .run_i        (ctl_q[EN_BIT]),
    .strobe_i     (strobe),
    .hold_i       (ctl_we | init_we),
    .load_i       (load),
    .load_val_i   (load_val),
    .reload_val_i (init_q),
    .periodic_i   (ctl_q[PER_BIT]),
    .count_o      (count_q),
    .zero_o       (zero_evt),
    .expire_o     (expire_o)
  );

  AST_CRST_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[CRST_BIT]);  // R8

  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctl_q & RSVD_MASK) == '0);  // R2

  AST_ACT_TRACKS_EN: assert property (@(posedge clk) disable iff (rst)
    ctl_q[ACT_BIT] == ctl_q[EN_BIT]);  // R7

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
    (zero_evt && !ctl_q[PER_BIT] && !ctl_we) |=> !ctl_q[EN_BIT]);  // R4
endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b1;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic        init_we = 1'b0;
  logic [31:0] init_wdata = '0;
  logic [31:0] ctl_q, init_q, count_q;
  logic        expire_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .init_we(init_we), .init_wdata(init_wdata),
    .ctl_q(ctl_q), .init_q(init_q), .count_q(count_q), .expire_o(expire_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_init(input logic [31:0] v);
    init_we = 1'b1; init_wdata = v;
    @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl_q, 32'h5);
    chk("R1 init", init_q, 32'h0);
    chk("R1 count", count_q, 32'h0);
    chk("R1 expire", {31'd0, expire_o}, 32'h0);
  endtask

  task automatic t_masking;
    wr_ctl(32'h23FF_FF03);
    chk("R2 masked readback", ctl_q, 32'h2000_0003);
  endtask

  task automatic t_init_load;
    wr_init(32'd10);
    chk("R3 init_q", init_q, 32'd10);
    chk("R3 count loaded", count_q, 32'd10);
  endtask

  task automatic t_oneshot;
    wr_ctl(32'h4000_0000);
    chk("R7 active set", ctl_q, 32'h4200_0000);
    cyc(4);
    chk("R10 count after 4", count_q, 32'd6);
    cyc(6);
    chk("R4 count zero", count_q, 32'd0);
    chk("R5 pulse high", {31'd0, expire_o}, 32'd1);
    chk("R4 en/act cleared", ctl_q, 32'h0);
    cyc(1);
    chk("R5 pulse one clock", {31'd0, expire_o}, 32'd0);
    cyc(3);
    chk("R10 no wrap", count_q, 32'd0);
  endtask

  task automatic t_periodic;
    wr_init(32'd3);
    wr_ctl(32'h4800_0001);
    cyc(5);
    chk("R6 before zero", {31'd0, expire_o}, 32'd0);
    cyc(1);
    chk("R6 expire", {31'd0, expire_o}, 32'd1);
    chk("R6 reloaded", count_q, 32'd3);
    chk("R6 still enabled", ctl_q, 32'h4A00_0001);
    cyc(1);
    chk("R5 pulse ends", {31'd0, expire_o}, 32'd0);
    cyc(5);
    chk("R6 second expire", {31'd0, expire_o}, 32'd1);
    wr_ctl(32'h0);
  endtask

  task automatic t_pause;
    wr_init(32'd8);
    wr_ctl(32'h4000_0000);
    cyc(3);
    chk("R10 count 5", count_q, 32'd5);
    wr_ctl(32'h0);
    chk("R11 write edge no decrement", count_q, 32'd5);
    chk("R7 act cleared", ctl_q, 32'h0);
    cyc(5);
    chk("R7 frozen", count_q, 32'd5);
    wr_ctl(32'h4000_0000);
    cyc(2);
    chk("R7 resumed from frozen", count_q, 32'd3);
  endtask

  task automatic t_crst_en;
    wr_ctl(32'h4400_0000);
    chk("R8 reloaded", count_q, 32'd8);
    chk("R8 en dropped, crst 0", ctl_q, 32'h0);
    cyc(3);
    chk("R8 stopped", count_q, 32'd8);
  endtask

  task automatic t_tick_gate;
    tick_i = 1'b0;
    wr_ctl(32'h4000_0000);
    cyc(5);
    chk("R10 no tick no count", count_q, 32'd8);
    tick_i = 1'b1;
    cyc(2);
    chk("R10 ticks counted", count_q, 32'd6);
  endtask

  task automatic t_psc_change;
    wr_ctl(32'h4000_0003);
    chk("R9 count kept", count_q, 32'd6);
    chk("R9 ctl", ctl_q, 32'h4200_0003);
    cyc(3);
    chk("R9 not yet", count_q, 32'd6);
    cyc(1);
    chk("R9 div by 4", count_q, 32'd5);
    cyc(4);
    chk("R9 div by 4 again", count_q, 32'd4);
    wr_init(32'd20);
    chk("R3 reload while running", count_q, 32'd20);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_masking();
    t_init_load();
    t_oneshot();
    t_periodic();
    t_pause();
    t_crst_en();
    t_tick_gate();
    t_psc_change();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule